// File: doc/BRIEF.md
# UART Sleep and Low-Power Gate Controller

This block decides when a UART core may stop its clock and when it has to run again. Software sets two enable bits: one for sleep, which stops both the core clock and the oscillator, and one for low-power, which stops only the core clock and leaves the oscillator running. The controller watches a set of activity inputs. These are a byte held in the transmitter, a change on the serial receive line, loopback mode, the four modem change flags (CTS, DSR and DCD change, and ring trailing edge), and a pending enabled interrupt. It drives two enables, one for a core clock gate and one for the oscillator.

The controller runs on an always-on clock. The clock gates, the oscillator and the modem change detectors sit outside it. The block enters a gated state only after every wake condition has been false at two clock edges in a row. Any wake condition restores both enables combinationally, in the same cycle it appears. A change on the receive line is synchronised first. It then holds the core awake for a programmable character time.

Top module: `uart_pwr_ctl`

## Requirements
- R1: After reset the controller is awake: `core_clk_en_o` and `osc_en_o` are both 1.
- R2: With `slp_en_i` = 1 and no wake condition, the controller enters sleep, and both `core_clk_en_o` and `osc_en_o` go to 0. `osc_en_o` is never 0 unless `slp_en_i` is 1.
- R3: With `lp_en_i` = 1 and `slp_en_i` = 0, entry gives `core_clk_en_o` = 0 and `osc_en_o` = 1. When both enables are 1 at entry, sleep is chosen. `osc_en_o` = 0 always implies `core_clk_en_o` = 0.
- R4: With both enables at 0, `core_clk_en_o` stays at 1 whatever the inputs are.
- R5: `tx_busy_i` = 1 or `loop_i` = 1 forces both enables to 1.
- R6: Any of `cts_chg_i`, `dsr_chg_i`, `dcd_chg_i` or `ring_end_i` at 1 forces both enables to 1.
- R7: `irq_pend_i` = 1 forces both enables to 1 and blocks entry.
- R8: A level change on `rx_line_i` passes through a 2-flop synchroniser. The outputs go high after the second clock edge that follows the change. Receive activity then lasts for the detection cycle plus `char_time_i` further cycles.
- R9: Entry happens at a clock edge only if the wake condition was also false at the previous edge. Both enables therefore stay at 1 for at least two edges of quiet.
- R10: A wake condition that appears while gated raises the enables in the same cycle, without waiting for an edge. The controller is awake again from the next edge.
- R11: Clearing the enable bit of the current gated mode raises the enables at once and returns the controller to awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slp_en_i | input | 1 | Sleep mode enable |
| lp_en_i | input | 1 | Low-power mode enable |
| char_time_i | input | CNT_W | Character time in clock cycles |
| tx_busy_i | input | 1 | Transmitter holds a byte |
| rx_line_i | input | 1 | Asynchronous serial receive line |
| loop_i | input | 1 | Loopback mode active |
| cts_chg_i | input | 1 | CTS change flag |
| dsr_chg_i | input | 1 | DSR change flag |
| dcd_chg_i | input | 1 | DCD change flag |
| ring_end_i | input | 1 | Ring indicator trailing-edge flag |
| irq_pend_i | input | 1 | Enabled interrupt pending |
| core_clk_en_o | output | 1 | Core clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
Entry and wake-up can fall in the same cycle. The quiet counter may mature at the very edge where a new wake source appears, and an enable bit may drop while an entry is already decided. The bench provokes this with directed wake pulses placed one and two edges into a quiet run, and with random stimulus where the wake sources are rare. It judges the result at every cycle against a cycle model, checking that the enables never drop while a wake is present and that the gated state is left at the following edge.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_AWAKE  = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_LOWPWR = 2'd2
  } pwr_state_e;

  localparam int RX_SYNC_STAGES = 2;
endpackage

// File: rtl/uart_pwr_rxsync.sv
module uart_pwr_rxsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic change_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '1;
    else         sh <= {sh[STAGES-1:0], line_i};
  end

  assign change_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/uart_pwr_hold.sv
module uart_pwr_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (trig_i)       cnt <= len_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active_o = trig_i | (cnt != '0);
endmodule

// File: rtl/uart_pwr_fsm.sv
module uart_pwr_fsm
  import uart_pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic slp_en_i,
  input  logic lp_en_i,
  output logic core_en_o,
  output logic osc_en_o
);
  pwr_state_e state_q, state_d;
  logic       quiet_q;
  logic       mode_ok;
  logic       gated;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_AWAKE: begin
        if (!wake_i && quiet_q) begin
          if (slp_en_i)     state_d = PWR_SLEEP;
          else if (lp_en_i) state_d = PWR_LOWPWR;
        end
      end
      PWR_SLEEP:  if (wake_i || !slp_en_i) state_d = PWR_AWAKE;
      PWR_LOWPWR: if (wake_i || !lp_en_i)  state_d = PWR_AWAKE;
      default:    state_d = PWR_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_AWAKE;
      quiet_q <= 1'b0;
    end else begin
      state_q <= state_d;
      quiet_q <= !wake_i;
    end
  end

  assign mode_ok   = (state_q == PWR_SLEEP) ? slp_en_i : lp_en_i;
  assign gated     = (state_q != PWR_AWAKE) && !wake_i && mode_ok;
  assign core_en_o = !gated;
  assign osc_en_o  = !(gated && (state_q == PWR_SLEEP));
endmodule

// File: rtl/uart_pwr_ctl.sv
module uart_pwr_ctl
  import uart_pwr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slp_en_i,
  input  logic             lp_en_i,
  input  logic [CNT_W-1:0] char_time_i,
  input  logic             tx_busy_i,
  input  logic             rx_line_i,
  input  logic             loop_i,
  input  logic             cts_chg_i,
  input  logic             dsr_chg_i,
  input  logic             dcd_chg_i,
  input  logic             ring_end_i,
  input  logic             irq_pend_i,
  output logic             core_clk_en_o,
  output logic             osc_en_o
);
  logic rx_change;
  logic rx_active;
  logic modem_wake;
  logic wake;

  uart_pwr_rxsync #(.STAGES(RX_SYNC_STAGES)) u_rxsync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (rx_line_i),
    .change_o (rx_change)
  );

  uart_pwr_hold #(.CNT_W(CNT_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (rx_change),
    .len_i    (char_time_i),
    .active_o (rx_active)
  );

  assign modem_wake = cts_chg_i | dsr_chg_i | dcd_chg_i | ring_end_i;
  assign wake       = tx_busy_i | loop_i | rx_active | modem_wake | irq_pend_i;

  uart_pwr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wake_i    (wake),
    .slp_en_i  (slp_en_i),
    .lp_en_i   (lp_en_i),
    .core_en_o (core_clk_en_o),
    .osc_en_o  (osc_en_o)
  );
endmodule

// File: rtl/uart_pwr_ctl_chk.sv
module uart_pwr_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic slp_en_i,
  input logic lp_en_i,
  input logic tx_busy_i,
  input logic loop_i,
  input logic cts_chg_i,
  input logic dsr_chg_i,
  input logic dcd_chg_i,
  input logic ring_end_i,
  input logic irq_pend_i,
  input logic core_clk_en_o,
  input logic osc_en_o
);
  logic direct_wake;
  assign direct_wake = tx_busy_i | loop_i | cts_chg_i | dsr_chg_i |
                       dcd_chg_i | ring_end_i | irq_pend_i;

  AST_OSC_OFF_NEEDS_SLEEP_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> slp_en_i); // R2

  AST_OSC_OFF_IMPLIES_CORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !core_clk_en_o); // R3

  AST_GATE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_clk_en_o |-> (slp_en_i || lp_en_i)); // R4

  AST_DIRECT_WAKE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_wake |-> (core_clk_en_o && osc_en_o)); // R5

  AST_ENTRY_AFTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> !$past(direct_wake)); // R9
endmodule

bind uart_pwr_ctl uart_pwr_ctl_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .slp_en_i      (slp_en_i),
  .lp_en_i       (lp_en_i),
  .tx_busy_i     (tx_busy_i),
  .loop_i        (loop_i),
  .cts_chg_i     (cts_chg_i),
  .dsr_chg_i     (dsr_chg_i),
  .dcd_chg_i     (dcd_chg_i),
  .ring_end_i    (ring_end_i),
  .irq_pend_i    (irq_pend_i),
  .core_clk_en_o (core_clk_en_o),
  .osc_en_o      (osc_en_o)
);

// File: tb/test_uart_pwr_ctl.sv
module test_uart_pwr_ctl;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp_en = 1'b0, lp_en = 1'b0;
  logic [CNT_W-1:0] char_time = 16'd4;
  logic tx_busy = 1'b0, rx_line = 1'b1, loopb = 1'b0;
  logic cts_c = 1'b0, dsr_c = 1'b0, dcd_c = 1'b0, ring_e = 1'b0, irq = 1'b0;
  logic core_en, osc_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_pwr_ctl #(.CNT_W(CNT_W)) i_uart_pwr_ctl (
    .clk_i(clk), .rst_ni(rst_n), .slp_en_i(slp_en), .lp_en_i(lp_en),
    .char_time_i(char_time), .tx_busy_i(tx_busy), .rx_line_i(rx_line),
    .loop_i(loopb), .cts_chg_i(cts_c), .dsr_chg_i(dsr_c), .dcd_chg_i(dcd_c),
    .ring_end_i(ring_e), .irq_pend_i(irq),
    .core_clk_en_o(core_en), .osc_en_o(osc_en)
  );

  // cycle model built from the requirements: 0 awake, 1 sleep, 2 low-power
  logic [2:0] m_sh = 3'b111;
  logic [CNT_W-1:0] m_cnt = '0;
  logic m_quiet = 1'b0;
  int   m_state = 0;

  function automatic logic m_wake();
    logic rx_act;
    rx_act = (m_sh[2] ^ m_sh[1]) | (m_cnt != '0);
    return tx_busy | loopb | cts_c | dsr_c | dcd_c | ring_e | irq | rx_act;
  endfunction

  function automatic logic m_gated();
    logic ok;
    ok = (m_state == 1) ? slp_en : lp_en;
    return (m_state != 0) && !m_wake() && ok;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 3'b111; m_cnt = '0; m_quiet = 1'b0; m_state = 0;
    end else begin
      logic w, chg;
      w   = m_wake();
      chg = m_sh[2] ^ m_sh[1];
      case (m_state)
        0: if (!w && m_quiet) m_state = slp_en ? 1 : (lp_en ? 2 : 0);
        1: if (w || !slp_en) m_state = 0;
        default: if (w || !lp_en) m_state = 0;
      endcase
      m_quiet = !w;
      if (chg) m_cnt = char_time;
      else if (m_cnt != '0) m_cnt = m_cnt - 1'b1;
      m_sh = {m_sh[1:0], rx_line};
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model(input string req);
    logic g;
    g = m_gated();
    check(req, core_en, !g, "core_clk_en model");
    check(req, osc_en, !(g && m_state == 1), "osc_en model");
  endtask

  task automatic tick(input string req);
    @(negedge clk); #1;
    cmp_model(req);
  endtask

  task automatic quiet_all();
    tx_busy = 0; loopb = 0; cts_c = 0; dsr_c = 0; dcd_c = 0; ring_e = 0; irq = 0;
  endtask

  task automatic set_src(input int k, input logic v);
    case (k)
      0: tx_busy = v;
      1: loopb = v;
      2: cts_c = v;
      3: dsr_c = v;
      4: dcd_c = v;
      5: ring_e = v;
      default: irq = v;
    endcase
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", core_en, 1'b1, "core after reset");
    check("R1", osc_en, 1'b1, "osc after reset");

    // R9 / R2: sleep entry after two quiet edges
    slp_en = 1;
    tick("R9");
    check("R9", core_en, 1'b1, "still awake after one quiet edge");
    tick("R2");
    check("R2", core_en, 1'b0, "core in sleep");
    check("R2", osc_en, 1'b0, "osc in sleep");

    // R10: same-cycle exit
    tx_busy = 1; #1;
    check("R10", core_en, 1'b1, "core wakes same cycle");
    check("R10", osc_en, 1'b1, "osc wakes same cycle");
    tick("R10");
    tx_busy = 0;
    repeat (2) tick("R9");
    check("R2", osc_en, 1'b0, "asleep again");

    // R11: enable cleared while asleep, then R3 low-power entry
    slp_en = 0; lp_en = 1; #1;
    check("R11", core_en, 1'b1, "enable drop wakes");
    repeat (3) tick("R3");
    check("R3", core_en, 1'b0, "core gated in low-power");
    check("R3", osc_en, 1'b1, "osc kept in low-power");

    // R3: both enabled picks sleep
    slp_en = 1; tx_busy = 1; tick("R3"); tx_busy = 0;
    repeat (3) tick("R3");
    check("R3", osc_en, 1'b0, "sleep wins over low-power");

    // R4: no enable, no gating
    slp_en = 0; lp_en = 0;
    repeat (4) tick("R4");
    check("R4", core_en, 1'b1, "no enable stays awake");

    // R5 R6 R7: each direct source wakes and holds
    slp_en = 1;
    for (int k = 0; k < 7; k++) begin
      string rq;
      rq = (k < 2) ? "R5" : ((k < 6) ? "R6" : "R7");
      repeat (3) tick(rq);
      check(rq, core_en, 1'b0, "asleep before source");
      set_src(k, 1'b1); #1;
      check(rq, core_en, 1'b1, "source wakes core");
      check(rq, osc_en, 1'b1, "source wakes osc");
      repeat (3) tick(rq);
      check(rq, core_en, 1'b1, "source holds awake");
      set_src(k, 1'b0);
    end

    // R8: receive line change with char time 4
    repeat (3) tick("R8");
    char_time = 16'd4;
    rx_line = 0;
    tick("R8"); check("R8", core_en, 1'b0, "one edge: not yet synced");
    tick("R8"); check("R8", core_en, 1'b1, "two edges: awake");
    repeat (6) tick("R8");
    check("R8", core_en, 1'b1, "held through character time");
    tick("R9"); check("R9", core_en, 1'b0, "asleep two edges after hold ends");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tx_busy = ($urandom % 24) == 0;
      loopb   = ($urandom % 64) == 0;
      cts_c   = ($urandom % 48) == 0;
      dsr_c   = ($urandom % 48) == 0;
      dcd_c   = ($urandom % 48) == 0;
      ring_e  = ($urandom % 48) == 0;
      irq     = ($urandom % 24) == 0;
      if (($urandom % 20) == 0) rx_line = ~rx_line;
      if (($urandom % 60) == 0) slp_en = $urandom % 2;
      if (($urandom % 60) == 0) lp_en = $urandom % 2;
      if (($urandom % 100) == 0) char_time = CNT_W'($urandom % 8);
      #1;
      cmp_model("R10");
      tick("R9");
    end
    quiet_all();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule